// File: doc/BRIEF.md
# Serial Presence-Detect Configuration Memory (Two-Wire Slave)

This block is a slave on a two-wire I2C bus that holds a 256-byte configuration image, such as the identity and timing table a memory module reports to its host. A host addresses it by a 7-bit device address. It can set an internal byte pointer and write one byte at a time, or read any number of bytes starting at a chosen or current address. The pointer advances after each byte and rolls over at the end of the array.

Two protection rules guard the image. The lower half is fixed at manufacture and never accepts a write. The upper half is open to writes unless an external protect pin is driven high; a board that leaves the pin pulled down keeps the region writable. A blocked write is still acknowledged on the bus but changes nothing. A system clock oversamples SCL and SDA, so SCL must be well below the system clock rate. The data line is open-drain: the block only ever pulls it low. Its contents after reset come from a parameter.

Top module: `presence_eeprom`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth clock) a device byte whose upper seven bits equal 1010 followed by strap_i[2:0]. It leaves SDA released for any other address and ignores the bus until the next START.
- R2: A write transaction is a device byte with bit 0 = 0, then a word-address byte, then a data byte, and all three are acknowledged. When the address has bit 7 = 1 and wp_i is low, the data byte is stored there.
- R3: A write to an address 0..127 (bit 7 = 0) is acknowledged but leaves the stored byte unchanged.
- R4: While wp_i is high, a write to an address 128..255 is acknowledged but leaves the stored byte unchanged.
- R5: A random read is a device write byte, a word address, a repeated START and a device byte with bit 0 = 1. It returns the byte at that word address, with the MSB first on SDA.
- R6: During a read, each byte the master acknowledges is followed by the byte at the next address. The address wraps from 255 to 0.
- R7: After a write of one data byte to address A, a read with no word address (current-address read) returns the byte at A+1 mod 256.
- R8: After reset, byte i holds the INIT parameter byte i. By default this is (37*i + 11) mod 256.
- R9: SDA is released after reset, after a master NACK ends a read, and after a STOP.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_o | output | 1 | Data line output value (always low) |
| sda_oe | output | 1 | High to pull the data line low |
| wp_i | input | 1 | Write-protect for the upper half, high blocks writes |
| strap_i | input | 3 | Low three bits of the device address |

## Verification
The assertions check on every cycle that no write strobe reaches the lower half, that a high protect pin holds off every store, that stores occur only on a completed data byte, that the SDA drive holds still while the synchronized SCL stays high, and that a STOP releases the line. Address matching, the acknowledge pattern, the read data order, pointer wrap and the current-address pointer after a write depend on whole transactions. Only the bench's transactions can show these, and it compares every read byte with a model of the image that follows the protection rules.

// File: rtl/pe_pkg.sv
`timescale 1ns/1ps
package pe_pkg;
  localparam int PE_AW    = 8;
  localparam int PE_DEPTH = 1 << PE_AW;

  typedef enum logic [3:0] {
    S_IDLE, S_DEV, S_DEV_ACK, S_WADR, S_WADR_ACK,
    S_WDAT, S_WDAT_ACK, S_RDAT, S_RACK
  } pe_state_t;

  function automatic logic [PE_DEPTH*8-1:0] pe_default_image();
    logic [PE_DEPTH*8-1:0] img;
    for (int i = 0; i < PE_DEPTH; i++) img[i*8 +: 8] = 8'((i * 37 + 11) % 256);
    return img;
  endfunction
endpackage

// File: rtl/pe_line_sync.sv
`timescale 1ns/1ps
module pe_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/pe_mem_array.sv
`timescale 1ns/1ps
module pe_mem_array #(
  parameter int AW = 8,
  parameter logic [(1<<AW)*8-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic          wr_req,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          wp_i,
  output logic          mem_we
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] mem [DEPTH];

  // lower half locked for good; upper half gated by the protect pin
  assign mem_we  = wr_req & wr_addr[AW-1] & ~wp_i;
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT[i*8 +: 8];
    end else if (mem_we) begin
      mem[wr_addr] <= wr_data;
    end
  end
endmodule

// File: rtl/pe_slave_fsm.sv
`timescale 1ns/1ps
module pe_slave_fsm
  import pe_pkg::*;
#(
  parameter int AW = 8,
  parameter logic [3:0] DEV_HI = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          sda_s,
  input  logic [2:0]    strap,
  input  logic [7:0]    rd_data,
  output logic [AW-1:0] ptr,
  output logic          wr_req,
  output logic [7:0]    wr_data,
  output logic          sda_oe
);
  pe_state_t st, st_n;
  logic [3:0]    cnt, cnt_n;
  logic [7:0]    sh, sh_n;
  logic [AW-1:0] ptr_n;
  logic          oe_n, nack, nack_n;

  always_comb begin
    st_n = st; cnt_n = cnt; sh_n = sh; ptr_n = ptr;
    oe_n = sda_oe; nack_n = nack; wr_req = 1'b0;
    if (stop_det) begin
      st_n = S_IDLE; oe_n = 1'b0;
    end else if (start_det) begin
      st_n = S_DEV; cnt_n = '0; oe_n = 1'b0;
    end else begin
      case (st)
        S_DEV, S_WADR, S_WDAT: begin
          if (scl_rise && cnt < 4'd8) begin
            sh_n  = {sh[6:0], sda_s};
            cnt_n = cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt_n = '0;
            if (st == S_DEV) begin
              if (sh[7:1] == {DEV_HI, strap}) begin
                st_n = S_DEV_ACK; oe_n = 1'b1;
              end else begin
                st_n = S_IDLE;
              end
            end else if (st == S_WADR) begin
              ptr_n = sh[AW-1:0]; st_n = S_WADR_ACK; oe_n = 1'b1;
            end else begin
              wr_req = 1'b1; ptr_n = ptr + 1'b1;
              st_n = S_WDAT_ACK; oe_n = 1'b1;
            end
          end
        end
        S_DEV_ACK: if (scl_fall) begin
          if (sh[0]) begin
            st_n = S_RDAT; sh_n = rd_data; oe_n = ~rd_data[7]; cnt_n = '0;
          end else begin
            st_n = S_WADR; oe_n = 1'b0;
          end
        end
        S_WADR_ACK, S_WDAT_ACK: if (scl_fall) begin
          st_n = S_WDAT; oe_n = 1'b0;
        end
        S_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 4'd1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              st_n = S_RACK; oe_n = 1'b0; ptr_n = ptr + 1'b1;
            end else begin
              sh_n = {sh[6:0], 1'b0}; oe_n = ~sh[6];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (nack) begin
              st_n = S_IDLE;
            end else begin
              st_n = S_RDAT; sh_n = rd_data; oe_n = ~rd_data[7]; cnt_n = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sh <= '0; ptr <= '0;
      sda_oe <= 1'b0; nack <= 1'b0;
    end else begin
      st <= st_n; cnt <= cnt_n; sh <= sh_n; ptr <= ptr_n;
      sda_oe <= oe_n; nack <= nack_n;
    end
  end

  assign wr_data = sh;
endmodule

// File: rtl/presence_eeprom.sv
`timescale 1ns/1ps
module presence_eeprom #(
  parameter int AW = pe_pkg::PE_AW,
  parameter logic [3:0] DEV_HI = 4'b1010,
  parameter int SYNC_STAGES = 2,
  parameter logic [(1<<AW)*8-1:0] INIT = pe_pkg::pe_default_image()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_o,
  output logic       sda_oe,
  input  logic       wp_i,
  input  logic [2:0] strap_i
);
  logic [1:0]    rst_pipe;
  logic          rst_sn;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [AW-1:0] ptr;
  logic [7:0]    rd_data, wr_data;
  logic          wr_req, mem_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  pe_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  pe_slave_fsm #(.AW(AW), .DEV_HI(DEV_HI)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_s(sda_s),
    .strap(strap_i), .rd_data(rd_data), .ptr(ptr), .wr_req(wr_req),
    .wr_data(wr_data), .sda_oe(sda_oe)
  );

  pe_mem_array #(.AW(AW), .INIT(INIT)) u_mem (
    .clk(clk), .rst_n(rst_sn), .rd_addr(ptr), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(ptr), .wr_data(wr_data), .wp_i(wp_i),
    .mem_we(mem_we)
  );

  assign sda_o = 1'b0;
endmodule

// File: rtl/pe_checker.sv
`timescale 1ns/1ps
module pe_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          stop_det,
  input logic          wr_req,
  input logic          mem_we,
  input logic [AW-1:0] wr_addr,
  input logic          wp_i
);
  AST_LOWER_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_addr[AW-1]); // R3
  AST_PROTECT_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    wp_i |-> !mem_we); // R4
  AST_STORE_ON_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> wr_req); // R2
  AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe)); // R10
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R9
endmodule

bind presence_eeprom pe_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_sn), .scl_s(scl_s), .sda_oe(sda_oe),
  .stop_det(stop_det), .wr_req(wr_req), .mem_we(mem_we),
  .wr_addr(ptr), .wp_i(wp_i)
);

// File: tb/sim_presence_eeprom.sv
`timescale 1ns/1ps
module sim_presence_eeprom;
  localparam int Q = 40;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_o, sda_oe;
  logic sda_bus;
  int checks = 0, errors = 0, r10_viol = 0;
  bit done = 1'b0;
  logic [7:0] model [256];
  logic [7:0] mptr;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  presence_eeprom u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_o(sda_o), .sda_oe(sda_oe), .wp_i(wp), .strap_i(STRAP)
  );

  function automatic logic [7:0] init_byte(int i);
    return 8'((i * 37 + 11) % 256);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // R10 monitor: drive must not move while SCL is high
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe !== oe_prev)) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic put_bit(logic b);
    m_sda = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
  endtask

  task automatic send_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; #Q; scl = 1'b1; #Q; ack = ~sda_bus; #Q; scl = 1'b0; #Q;
  endtask

  task automatic get_byte(bit more, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      #Q; scl = 1'b1; #Q; d = {d[6:0], sda_bus}; #Q; scl = 1'b0;
    end
    #Q; m_sda = more ? 1'b0 : 1'b1;
    #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q; m_sda = 1'b1;
  endtask

  task automatic do_start();
    m_sda = 1'b1; #Q; scl = 1'b1; #Q; m_sda = 1'b0; #Q; scl = 1'b0; #Q;
  endtask

  task automatic do_stop();
    m_sda = 1'b0; #Q; scl = 1'b1; #Q; m_sda = 1'b1; #Q;
    check(sda_oe == 1'b0, "R9 released after STOP", sda_oe, 0);
  endtask

  task automatic wr_txn(logic [7:0] a, logic [7:0] d, logic wpv);
    logic ack;
    string req;
    wp = wpv;
    req = !a[7] ? "R3" : (wpv ? "R4" : "R2");
    do_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack); check(ack, "R1 device ack", ack, 1);
    send_byte(a, ack); check(ack, "R2 word address ack", ack, 1);
    send_byte(d, ack); check(ack, req, ack, 1);
    do_stop();
    if (a[7] && !wpv) model[a] = d;
    mptr = a + 8'd1;
    wp = 1'b0;
  endtask

  task automatic rd_txn(logic [7:0] a, int n, string req);
    logic ack;
    logic [7:0] d;
    do_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack); check(ack, "R1 device ack", ack, 1);
    send_byte(a, ack); check(ack, "R5 word address ack", ack, 1);
    do_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack); check(ack, "R5 read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      check(d == model[8'(a + i)], req, d, model[8'(a + i)]);
    end
    check(sda_oe == 1'b0, "R9 released after NACK", sda_oe, 0);
    do_stop();
    mptr = 8'(a + n);
  endtask

  task automatic cur_rd(int n);
    logic ack;
    logic [7:0] d;
    do_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack); check(ack, "R7 read ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      get_byte(i < n - 1, d);
      check(d == model[8'(mptr + i)], "R7 current-address read", d, model[8'(mptr + i)]);
    end
    do_stop();
    mptr = 8'(mptr + n);
  endtask

  initial begin
    #900us;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic ack;
    for (int i = 0; i < 256; i++) model[i] = init_byte(i);
    mptr = 8'd0;
    void'($urandom(32'd4242));
    #21; rst_n = 1'b1; #100;
    check(sda_oe == 1'b0, "R9 released after reset", sda_oe, 0);

    rd_txn(8'd0, 4, "R8 reset contents");
    rd_txn(8'd200, 3, "R8 reset contents");

    // R1 wrong address: no acknowledge
    do_start();
    send_byte({4'b1010, ~STRAP, 1'b0}, ack); check(!ack, "R1 foreign address nack", ack, 0);
    do_stop();
    do_start();
    send_byte({4'b0110, STRAP, 1'b1}, ack); check(!ack, "R1 foreign prefix nack", ack, 0);
    do_stop();

    wr_txn(8'd5, 8'hA5, 1'b0);    rd_txn(8'd5, 1, "R3 lower half locked");
    wr_txn(8'd127, 8'h3C, 1'b0);  rd_txn(8'd127, 1, "R3 lower half locked");
    wr_txn(8'd128, 8'h5A, 1'b0);  rd_txn(8'd128, 1, "R2 upper half written");
    wr_txn(8'd130, 8'hC3, 1'b1);  rd_txn(8'd130, 1, "R4 protect pin blocks");
    wr_txn(8'd255, 8'h96, 1'b0);  cur_rd(2);
    rd_txn(8'd253, 5, "R6 sequential wrap");
    wr_txn(8'd140, 8'h11, 1'b0);  cur_rd(1);
    rd_txn(8'd77, 2, "R5 random read");

    for (int k = 0; k < 24; k++) begin
      int op;
      logic [7:0] a;
      op = $urandom % 3;
      a  = 8'($urandom);
      if (op == 0)      wr_txn(a, 8'($urandom), 1'($urandom));
      else if (op == 1) rd_txn(a, 1 + ($urandom % 6), "R6 sequential read");
      else              cur_rd(1 + ($urandom % 3));
    end

    check(r10_viol == 0, "R10 SDA drive only with SCL low", r10_viol, 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule